// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This unit works out the architectural effect of a vector-configuration instruction. It receives the current vector type word and the current vector length, the type word the instruction asks for, and the requested application vector length. Two flags tell it whether the destination and the first source register specifiers name the zero register. It then produces the resulting type word, the largest vector length that type allows (VLMAX), the new vector length, and a strobe that tells the vector unit to clear its start index.

A request that matches the current type word is kept as is, with no legality checking. A differing request is checked. It is rejected when its group multiplier is out of range or reserved, when its element width is too wide for the multiplier, or when any reserved bit is set. A rejected request collapses to a type word that carries only the illegal flag. VLMAX is then zero, and so is the vector length. The new vector length follows the zero-register rules and is always clamped to VLMAX. VLMAX is built from shifts only, with no divider.

The block accepts one configuration per cycle in which `in_valid` is high. All outputs come from a single register stage and appear one clock later. Everything ahead of that register is combinational.

Top module: `vcfg_unit`

## Requirements
- R1: When `req_vtype` equals `cur_vtype` bit for bit, `new_vtype` equals `cur_vtype` and no legality check is applied, even if that word would fail one.
- R2: A differing request is illegal when its multiplier code (bits 2:0) is 4. Codes 0..3 mean LMUL 1, 2, 4, 8 and codes 5, 6, 7 mean 1/8, 1/4, 1/2.
- R3: A differing request is illegal when SEW = 8<<vsew (vsew in bits 5:3) exceeds ELEN times min(LMUL, 1).
- R4: A differing request is illegal when any of bits 62..8 is set.
- R5: An illegal request yields `new_vtype` = 64'h8000_0000_0000_0000 (only bit 63, the illegal flag, set) and `new_vlmax` = 0.
- R6: `new_vlmax` = VLEN*LMUL/SEW, rounded down, for the resulting type word. It is 0 when that word has bit 63 set or multiplier code 4. Bits 6 and 7 (tail and mask policy) pass through unchanged.
- R7: When `new_vlmax` is 0, `new_vl` is 0.
- R8: When both `rd_is_x0` and `rs1_is_x0` are high, `new_vl` = min(`cur_vl`, VLMAX).
- R9: When `rd_is_x0` is low and `rs1_is_x0` is high, `new_vl` = VLMAX.
- R10: When `rs1_is_x0` is low, `new_vl` = min(`req_avl`, VLMAX), whatever `rd_is_x0` is.
- R11: Results appear in the cycle after `in_valid` is high. `out_valid` and `vstart_clr` are high for exactly that cycle, and the data outputs hold their values while no input is valid.
- R12: Synchronous active-high reset clears `out_valid` and `vstart_clr` and zeroes `new_vtype`, `new_vl` and `new_vlmax`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A configuration request is present |
| cur_vtype | input | 64 | Current vector type word |
| cur_vl | input | VLW | Current vector length |
| req_vtype | input | 64 | Requested vector type word |
| req_avl | input | 64 | Requested application vector length |
| rd_is_x0 | input | 1 | Destination specifier is the zero register |
| rs1_is_x0 | input | 1 | First source specifier is the zero register |
| out_valid | output | 1 | Results below are fresh this cycle |
| new_vtype | output | 64 | Resulting vector type word |
| new_vl | output | VLW | Resulting vector length |
| new_vlmax | output | VLW | VLMAX of the resulting type |
| vstart_clr | output | 1 | Pulse that clears the start index |

VLW is $clog2(VLEN)+1.

## Verification
The bench builds the unit with VLEN = 128 and ELEN = 64, giving an 8-bit length path. VLMAX can then range from 1 (SEW 64 at LMUL 1/2, reachable only by keeping an unchecked current word) up to 128 (SEW 8 at LMUL 8). This makes both clamping directions observable. With ELEN at 64, a SEW of 128 fails the width rule at every multiplier, and SEW 64 passes at LMUL 1 but fails at LMUL 1/2. Reserved-bit checks are driven at both ends of the 62..8 range. Requested lengths far above VLMAX, and equal-word requests that would otherwise be illegal, are also exercised.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int TYPE_W   = 64;
  localparam int VILL_BIT = 63;
  localparam int RSVD_LO  = 8;
  localparam int RSVD_HI  = 62;
  localparam int RSVD_W   = RSVD_HI - RSVD_LO + 1;

  typedef logic [TYPE_W-1:0] vtype_t;
  typedef logic [2:0]        lmul_code_t;
  typedef logic [2:0]        sew_code_t;

  localparam vtype_t VILL_ONLY = vtype_t'(1) << VILL_BIT;
  localparam lmul_code_t LMUL_RSVD = 3'd4;

  // Right shift applied for fractional multipliers (codes 5..7), else 0.
  function automatic int frac_shift(lmul_code_t c);
    case (c)
      3'd5: return 3;
      3'd6: return 2;
      3'd7: return 1;
      default: return 0;
    endcase
  endfunction

  // Left shift applied for whole multipliers (codes 0..3), else 0.
  function automatic int whole_shift(lmul_code_t c);
    return c[2] ? 0 : int'(c[1:0]);
  endfunction
endpackage

// File: rtl/vcfg_legal.sv
module vcfg_legal
  import vcfg_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  lmul_code_t        lmul_i,
  input  sew_code_t         sew_i,
  input  logic [RSVD_W-1:0] rsvd_i,
  output logic              illegal_o
);
  localparam int ELOG = $clog2(ELEN);

  logic bad_lmul, bad_width, bad_rsvd;

  always_comb begin
    bad_lmul  = (lmul_i == LMUL_RSVD);
    // log2(SEW) = 3 + sew; limit log2 = ELOG - frac_shift
    bad_width = (3 + int'(sew_i) + frac_shift(lmul_i)) > ELOG;
    bad_rsvd  = |rsvd_i;
    illegal_o = bad_lmul | bad_width | bad_rsvd;
  end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VLOG = $clog2(VLEN),
  localparam int VLW  = VLOG + 1
) (
  input  logic           vill_i,
  input  lmul_code_t     lmul_i,
  input  sew_code_t      sew_i,
  output logic [VLW-1:0] vlmax_o
);
  int expo;

  always_comb begin
    // log2(VLEN * LMUL / SEW)
    expo = VLOG + whole_shift(lmul_i) - frac_shift(lmul_i) - 3 - int'(sew_i);
    if (vill_i || lmul_i == LMUL_RSVD || expo < 0)
      vlmax_o = '0;
    else
      vlmax_o = VLW'(1) << expo;
  end
endmodule

// File: rtl/vcfg_vl_pick.sv
module vcfg_vl_pick #(
  parameter int VLW   = 8,
  parameter int AVL_W = 64
) (
  input  logic [VLW-1:0]   vlmax_i,
  input  logic [VLW-1:0]   cur_vl_i,
  input  logic [AVL_W-1:0] avl_i,
  input  logic             rd_zero_i,
  input  logic             rs1_zero_i,
  output logic [VLW-1:0]   vl_o
);
  logic [AVL_W-1:0] vlmax_wide;
  assign vlmax_wide = AVL_W'(vlmax_i);

  always_comb begin
    if (vlmax_i == '0)
      vl_o = '0;
    else if (!rs1_zero_i)
      vl_o = (avl_i > vlmax_wide) ? vlmax_i : avl_i[VLW-1:0];
    else if (!rd_zero_i)
      vl_o = vlmax_i;
    else
      vl_o = (cur_vl_i > vlmax_i) ? vlmax_i : cur_vl_i;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [63:0]    cur_vtype,
  input  logic [VLW-1:0] cur_vl,
  input  logic [63:0]    req_vtype,
  input  logic [63:0]    req_avl,
  input  logic           rd_is_x0,
  input  logic           rs1_is_x0,
  output logic           out_valid,
  output logic [63:0]    new_vtype,
  output logic [VLW-1:0] new_vl,
  output logic [VLW-1:0] new_vlmax,
  output logic           vstart_clr
);
  logic           same_word;
  logic           req_bad;
  vtype_t         vtype_nxt;
  logic [VLW-1:0] vlmax_nxt;
  logic [VLW-1:0] vl_nxt;

  assign same_word = (req_vtype == cur_vtype);

  vcfg_legal #(.ELEN(ELEN)) u_legal (
    .lmul_i    (req_vtype[2:0]),
    .sew_i     (req_vtype[5:3]),
    .rsvd_i    (req_vtype[RSVD_HI:RSVD_LO]),
    .illegal_o (req_bad)
  );

  always_comb begin
    if (same_word)
      vtype_nxt = cur_vtype;
    else if (req_bad)
      vtype_nxt = VILL_ONLY;
    else
      vtype_nxt = req_vtype;
  end

  vcfg_vlmax #(.VLEN(VLEN)) u_vlmax (
    .vill_i  (vtype_nxt[VILL_BIT]),
    .lmul_i  (vtype_nxt[2:0]),
    .sew_i   (vtype_nxt[5:3]),
    .vlmax_o (vlmax_nxt)
  );

  vcfg_vl_pick #(.VLW(VLW), .AVL_W(64)) u_pick (
    .vlmax_i    (vlmax_nxt),
    .cur_vl_i   (cur_vl),
    .avl_i      (req_avl),
    .rd_zero_i  (rd_is_x0),
    .rs1_zero_i (rs1_is_x0),
    .vl_o       (vl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      vstart_clr <= 1'b0;
      new_vtype  <= '0;
      new_vl     <= '0;
      new_vlmax  <= '0;
    end else begin
      out_valid  <= in_valid;
      vstart_clr <= in_valid;
      if (in_valid) begin
        new_vtype <= vtype_nxt;
        new_vl    <= vl_nxt;
        new_vlmax <= vlmax_nxt;
      end
    end
  end
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [63:0]    cur_vtype,
  input logic [VLW-1:0] cur_vl,
  input logic [63:0]    req_vtype,
  input logic [63:0]    req_avl,
  input logic           rd_is_x0,
  input logic           rs1_is_x0,
  input logic           out_valid,
  input logic [63:0]    new_vtype,
  input logic [VLW-1:0] new_vl,
  input logic [VLW-1:0] new_vlmax,
  input logic           vstart_clr
);
  assert_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && vstart_clr));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !vstart_clr && $stable(new_vl) && $stable(new_vtype)));

  assert_keep_word_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && req_vtype == cur_vtype) |=> (new_vtype == $past(cur_vtype)));

  assert_vill_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && new_vtype[63]) |-> (new_vlmax == '0));

  assert_pow2_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(new_vlmax));

  assert_zero_vl_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && new_vlmax == '0) |-> (new_vl == '0));

  assert_cur_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_is_x0 && rs1_is_x0) |=> (new_vl <= $past(cur_vl) && new_vl <= new_vlmax));

  assert_full_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rd_is_x0 && rs1_is_x0) |=> (new_vl == new_vlmax));

  assert_avl_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rs1_is_x0) |=> (64'(new_vl) <= $past(req_avl) && new_vl <= new_vlmax));
endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cur_vtype(cur_vtype),
  .cur_vl(cur_vl), .req_vtype(req_vtype), .req_avl(req_avl),
  .rd_is_x0(rd_is_x0), .rs1_is_x0(rs1_is_x0), .out_valid(out_valid),
  .new_vtype(new_vtype), .new_vl(new_vl), .new_vlmax(new_vlmax),
  .vstart_clr(vstart_clr)
);

// File: tb/vcfg_unit_bench.sv
module vcfg_unit_bench;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VLW  = $clog2(VLEN) + 1;
  localparam logic [63:0] VILL = 64'h8000_0000_0000_0000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [63:0]    cur_vtype = '0;
  logic [VLW-1:0] cur_vl = '0;
  logic [63:0]    req_vtype = '0;
  logic [63:0]    req_avl = '0;
  logic           rd_is_x0 = 1'b1;
  logic           rs1_is_x0 = 1'b1;
  logic           out_valid, vstart_clr;
  logic [63:0]    new_vtype;
  logic [VLW-1:0] new_vl, new_vlmax;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN)) u_vcfg_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_vtype(cur_vtype),
    .cur_vl(cur_vl), .req_vtype(req_vtype), .req_avl(req_avl),
    .rd_is_x0(rd_is_x0), .rs1_is_x0(rs1_is_x0), .out_valid(out_valid),
    .new_vtype(new_vtype), .new_vl(new_vl), .new_vlmax(new_vlmax),
    .vstart_clr(vstart_clr)
  );

  function automatic logic [63:0] mk(int sew, int lmul, bit ta, bit ma);
    return {56'd0, ma, ta, 3'(sew), 3'(lmul)};
  endfunction

  // LMUL in eighths; 0 for the reserved code
  function automatic int lmul8(logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 16; 3'd2: return 32; 3'd3: return 64;
      3'd5: return 1;  3'd6: return 2;  3'd7: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_vlmax(logic [63:0] vt);
    int sew;
    sew = 8 << vt[5:3];
    if (vt[63] || lmul8(vt[2:0]) == 0) return 0;
    return (VLEN * lmul8(vt[2:0])) / (8 * sew);
  endfunction

  function automatic logic [63:0] ref_vtype(logic [63:0] cur, logic [63:0] req);
    int sew, lm, lim8;
    if (cur == req) return cur;
    sew = 8 << req[5:3];
    lm  = lmul8(req[2:0]);
    lim8 = (lm < 8) ? lm : 8;
    if (lm == 0 || sew * 8 > ELEN * lim8 || req[62:8] != 0) return VILL;
    return req;
  endfunction

  function automatic int ref_vl(int vmax, int cvl, longint unsigned avl, bit rdz, bit rsz);
    if (vmax == 0) return 0;
    if (!rsz) return (avl > longint'(vmax)) ? vmax : int'(avl);
    if (!rdz) return vmax;
    return (cvl > vmax) ? vmax : cvl;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issue one request and check all outputs in the next cycle.
  task automatic run(string req, logic [63:0] cvt, int cvl, logic [63:0] rvt,
                     longint unsigned avl, bit rdz, bit rsz);
    logic [63:0] evt;
    int emax;
    @(negedge clk);
    cur_vtype = cvt; cur_vl = VLW'(cvl); req_vtype = rvt; req_avl = avl;
    rd_is_x0 = rdz; rs1_is_x0 = rsz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    evt  = ref_vtype(cvt, rvt);
    emax = ref_vlmax(evt);
    check(req, "vtype", new_vtype, evt);
    check(req, "vlmax", 64'(new_vlmax), 64'(emax));
    check(req, "vl", 64'(new_vl), 64'(ref_vl(emax, cvl, avl, rdz, rsz)));
    check("R11", "strobe", {62'd0, out_valid, vstart_clr}, 64'd3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12", "valid", {62'd0, out_valid, vstart_clr}, 64'd0);
    check("R12", "vtype", new_vtype, 64'd0);
    check("R12", "vl", 64'({new_vl, new_vlmax}), 64'd0);
  endtask

  task automatic t_avl();
    run("R10", 64'd0, 0, mk(2, 1, 0, 0), 64'd5, 1, 0);     // VLMAX 8, vl 5
    run("R10", 64'd0, 0, mk(2, 1, 0, 0), 64'd100, 0, 0);   // clamp to 8
    run("R10", 64'd0, 0, mk(0, 3, 0, 0), 64'hFFFF_FFFF_0000_0001, 1, 0);
    check("R10", "huge avl clamp", 64'(new_vl), 64'd128);
  endtask

  task automatic t_rd_only();
    run("R9", 64'd0, 3, mk(0, 3, 0, 0), 64'd7, 0, 1);      // VLMAX 128
    check("R9", "vl max", 64'(new_vl), 64'd128);
    run("R9", 64'd0, 3, mk(3, 0, 0, 0), 64'd7, 0, 1);      // VLMAX 2
  endtask

  task automatic t_both_x0();
    run("R8", 64'd0, 20, mk(1, 0, 0, 0), 64'd99, 1, 1);    // min(20,8)
    check("R8", "clamp cur", 64'(new_vl), 64'd8);
    run("R8", 64'd0, 3, mk(1, 0, 0, 0), 64'd99, 1, 1);     // keep 3
  endtask

  task automatic t_illegal();
    run("R2", 64'd0, 5, 64'h4, 64'd9, 0, 0);              // reserved LMUL
    check("R5", "vill only", new_vtype, VILL);
    check("R7", "vl zero", 64'(new_vl), 64'd0);
    run("R3", 64'd0, 5, mk(3, 7, 0, 0), 64'd9, 0, 0);      // SEW64 at 1/2
    run("R3", 64'd0, 5, mk(4, 0, 0, 0), 64'd9, 0, 0);      // SEW128
    run("R3", 64'd0, 5, mk(0, 5, 0, 0), 64'd9, 0, 0);      // SEW8 at 1/8 ok
    run("R4", 64'd0, 5, mk(1, 0, 0, 0) | (64'd1 << 8), 64'd9, 0, 0);
    run("R4", 64'd0, 5, mk(1, 0, 0, 0) | (64'd1 << 62), 64'd9, 0, 0);
    check("R4", "bit62 rejects", new_vtype, VILL);
  endtask

  task automatic t_keep();
    run("R1", mk(3, 7, 0, 0), 0, mk(3, 7, 0, 0), 64'd10, 1, 0);
    check("R1", "kept unchecked", new_vtype, mk(3, 7, 0, 0));
    check("R6", "vlmax 1", 64'(new_vlmax), 64'd1);
    run("R1", VILL, 4, VILL, 64'd10, 0, 1);
    check("R7", "kept vill vl", 64'(new_vl), 64'd0);
  endtask

  task automatic t_policy();
    run("R6", 64'd0, 0, mk(2, 2, 1, 1), 64'd3, 1, 0);
    check("R6", "policy bits", new_vtype, 64'hD2);
  endtask

  task automatic t_hold();
    logic [63:0] vt;
    logic [VLW-1:0] vl;
    run("R11", 64'd0, 0, mk(0, 1, 0, 0), 64'd11, 1, 0);
    vt = new_vtype; vl = new_vl;
    @(negedge clk);
    req_vtype = 64'h4; req_avl = 64'd1;
    repeat (2) @(negedge clk);
    check("R11", "idle strobe", {62'd0, out_valid, vstart_clr}, 64'd0);
    check("R11", "hold vtype", new_vtype, vt);
    check("R11", "hold vl", 64'(new_vl), 64'(vl));
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    cur_vtype = '0; req_vtype = mk(0, 0, 0, 0); req_avl = 64'd50;
    rd_is_x0 = 1; rs1_is_x0 = 0; in_valid = 1;
    @(negedge clk);
    check("R11", "b2b first vl", 64'(new_vl), 64'd16);
    req_vtype = mk(1, 0, 0, 0);
    @(negedge clk);
    in_valid = 0;
    check("R11", "b2b second vl", 64'(new_vl), 64'd8);
    check("R11", "b2b strobe", {62'd0, out_valid, vstart_clr}, 64'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_avl();
    t_rd_only();
    t_both_x0();
    t_illegal();
    t_keep();
    t_policy();
    t_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule